// File: doc/BRIEF.md
# Incrementing-Ramp Self-Test Monitor

This block watches the decoded character stream of a receive lane while the link runs its built-in self test. The far end sends a repeating frame: one or more idle characters (the K28.5 comma, carried as control byte 0xBC) and then a data ramp that climbs through every byte value from 0x00 to 0xFF. For each receive word clock the monitor takes one byte, a flag that marks the byte as a control character, and the decoder's error flag (code violation or running-disparity fault). It drives one pass/fail output, `pat_fail`.

The output is high while errors are present and low while the pattern arrives correctly. It is sticky-high. It drops only after at least one idle is followed by a complete, clean 256-byte ramp. It goes high again in the next cycle on any mismatch or decoder error. It stays high whenever self test is off, so it starts high on every rising edge of the enable. The checker is a four-state machine:

- **HUNT**: not locked. Characters are ignored until an idle arrives (transition *lock-idle*: HUNT to ARMED).
- **ARMED**: idles seen and the ramp start is awaited. A further idle stays here (*idle-repeat*). Data byte 0x00 enters RAMP (*ramp-start*). Anything else is a mismatch (*miss*: to HUNT).
- **RAMP**: each data byte must equal the running expected value. A match advances it (*ramp-step*). The match on 0xFF enters TAIL and clears the output (*ramp-done*). Anything else is a *miss*.
- **TAIL**: an idle is required (*tail-idle*: to ARMED). Anything else is a *miss*.

From every state, a decoder error with self test on takes *err-abort* to HUNT. Self test off or reset takes *disable* to HUNT.

Top module: `bist_ramp_checker`

## Requirements
- R1: A synchronous active-high reset leaves `pat_fail` high and the checker in the not-locked (hunt) condition.
- R2: While `test_en` is low, `pat_fail` is high after every clock, whatever characters arrive, and no ramp progress is kept.
- R3: On the clock after `test_en` rises, `pat_fail` is high, even if the link had passed before self test was dropped.
- R4: An idle is a character with `rx_is_ctrl` = 1 and `rx_byte` = 0xBC. After at least one idle, a data character (`rx_is_ctrl` = 0) of value 0x00 starts the ramp check.
- R5: `pat_fail` goes low on the clock that registers the 256th consecutive correct ramp byte (0x00 to 0xFF in order, following idles). It is never cleared any other way.
- R6: With `test_en` high, `rx_err` = 1 sets `pat_fail` high on the next clock and forces the checker to hunt. This holds even when the character itself matches.
- R7: During the ramp, a data byte that differs from the expected value sets `pat_fail` high on the next clock and forces hunt.
- R8: A control character other than the idle, anywhere, or an idle arriving inside the ramp, counts as a mismatch (R7 behaviour).
- R9: After the 256th ramp byte, a data character before at least one idle is a mismatch.
- R10: After a mismatch, characters are ignored until an idle. A full ramp with no preceding idle does not clear `pat_fail`. The next idle followed by a clean ramp does.
- R11: A first data byte after idles that is not 0x00 is a mismatch.
- R12: Repeated clean frames (idles then ramp) with any number of idles between them keep `pat_fail` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous reset, active high |
| test_en | input | 1 | Self-test enable |
| rx_byte | input | 8 | Decoded character |
| rx_is_ctrl | input | 1 | 1 = control character, 0 = data |
| rx_err | input | 1 | Decoder error for this character |
| pat_fail | output | 1 | 1 = errors detected / not yet passed, 0 = pattern correct |

## Verification
Two functions can fall in the same cycle. A decoder error can arrive on a character that the ramp check alone would accept, including the final 0xFF that would clear the output. The bench sends a correct ramp byte together with `rx_err` in mid-ramp and on the last byte. It then checks that the output is high on the next clock, with no one-cycle low pulse. A disable can also coincide with the ramp completion, and the disabled state must win. A behavioural reference model, written with integer positions, is compared with `pat_fail` after every clock.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RAMP  = 2'd2,
        ST_TAIL  = 2'd3
    } chk_state_t;

endpackage

// File: rtl/bist_char_class.sv
module bist_char_class #(
    parameter int            DATA_W    = 8,
    parameter logic [7:0]    IDLE_CODE = 8'hBC
) (
    input  logic [DATA_W-1:0] ch_byte,
    input  logic              ch_ctrl,
    output logic              is_idle,
    output logic              is_data,
    output logic              is_other_ctrl
);

    localparam logic [DATA_W-1:0] IDLE_W = DATA_W'(IDLE_CODE);

    always_comb begin
        is_data       = !ch_ctrl;
        is_idle       = ch_ctrl && (ch_byte == IDLE_W);
        is_other_ctrl = ch_ctrl && (ch_byte != IDLE_W);
    end

    // R8: every character falls into exactly one class
    always_comb begin
        if (!$isunknown({ch_ctrl, ch_byte}))
            a_r8_one_class: assert ($onehot({is_idle, is_data, is_other_ctrl}));
    end

endmodule

// File: rtl/bist_ramp_ctr.sv
module bist_ramp_ctr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    output logic [DATA_W-1:0] cnt,
    output logic              at_last
);

    localparam logic [DATA_W-1:0] LAST_VAL = {DATA_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + 1'b1;
    end

    always_comb at_last = (cnt == LAST_VAL);

    // R4: a cleared counter expects 0x00 for the ramp start
    a_r4_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R5: one step per accepted ramp byte
    a_r5_cnt_step: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/bist_seq_fsm.sv
module bist_seq_fsm
    import bist_chk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       test_en,
    input  logic       rx_err,
    input  logic       is_idle,
    input  logic       data_ok,
    input  logic       at_last,
    output logic       ctr_clr,
    output logic       ctr_adv,
    output logic       fail,
    output chk_state_t state
);

    chk_state_t nxt;
    logic       hit;
    logic       miss;
    logic       done;

    // next-state logic
    always_comb begin
        nxt  = state;
        hit  = 1'b0;
        miss = 1'b0;
        done = 1'b0;
        if (!test_en) begin
            nxt = ST_HUNT;
        end else if (rx_err) begin
            miss = 1'b1;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    if (is_idle) nxt = ST_ARMED;
                end
                ST_ARMED: begin
                    if (is_idle)      nxt = ST_ARMED;
                    else if (data_ok) begin
                        hit = 1'b1;
                        nxt = ST_RAMP;
                    end else          miss = 1'b1;
                end
                ST_RAMP: begin
                    if (data_ok) begin
                        hit = 1'b1;
                        if (at_last) begin
                            done = 1'b1;
                            nxt  = ST_TAIL;
                        end
                    end else begin
                        miss = 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (is_idle) nxt = ST_ARMED;
                    else         miss = 1'b1;
                end
                default: nxt = ST_HUNT;
            endcase
        end
        if (miss) nxt = ST_HUNT;
    end

    always_comb begin
        ctr_adv = hit;
        ctr_clr = !hit;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_HUNT;
        else     state <= nxt;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst || !test_en || miss) fail <= 1'b1;
        else if (done)               fail <= 1'b0;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (fail && state == ST_HUNT));

    a_r2_disabled_high: assert property (@(posedge clk) disable iff (rst)
        !test_en |=> (fail && state == ST_HUNT));

    a_r3_rise_high: assert property (@(posedge clk) disable iff (rst)
        $rose(test_en) |=> fail);

    a_r5_clear_at_tail: assert property (@(posedge clk) disable iff (rst)
        $fell(fail) |-> (state == ST_TAIL));

    a_r6_err_aborts: assert property (@(posedge clk) disable iff (rst)
        (test_en && rx_err) |=> (fail && state == ST_HUNT));

    a_r10_hunt_no_ramp: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HUNT) |=> (state != ST_RAMP));

endmodule

// File: rtl/bist_ramp_checker.sv
module bist_ramp_checker
    import bist_chk_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter logic [7:0] IDLE_CODE = 8'hBC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              test_en,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_is_ctrl,
    input  logic              rx_err,
    output logic              pat_fail
);

    logic              is_idle;
    logic              is_data;
    logic              is_other_ctrl;
    logic              data_ok;
    logic              ctr_clr;
    logic              ctr_adv;
    logic              at_last;
    logic [DATA_W-1:0] exp_val;
    chk_state_t        state;

    bist_char_class #(
        .DATA_W   (DATA_W),
        .IDLE_CODE(IDLE_CODE)
    ) u_class (
        .ch_byte      (rx_byte),
        .ch_ctrl      (rx_is_ctrl),
        .is_idle      (is_idle),
        .is_data      (is_data),
        .is_other_ctrl(is_other_ctrl)
    );

    bist_ramp_ctr #(
        .DATA_W(DATA_W)
    ) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctr_clr),
        .adv    (ctr_adv),
        .cnt    (exp_val),
        .at_last(at_last)
    );

    always_comb data_ok = is_data && (rx_byte == exp_val);

    bist_seq_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .test_en(test_en),
        .rx_err (rx_err),
        .is_idle(is_idle),
        .data_ok(data_ok),
        .at_last(at_last),
        .ctr_clr(ctr_clr),
        .ctr_adv(ctr_adv),
        .fail   (pat_fail),
        .state  (state)
    );

    // R8: a foreign control character never lets the ramp advance
    a_r8_ctrl_no_step: assert property (@(posedge clk) disable iff (rst)
        (test_en && is_other_ctrl) |=> pat_fail);

    // R9: a data byte right after ramp completion is rejected
    a_r9_tail_needs_idle: assert property (@(posedge clk) disable iff (rst)
        (test_en && state == ST_TAIL && is_data) |=> (pat_fail && state == ST_HUNT));

endmodule

// File: tb/sim_bist_ramp_checker.sv
module sim_bist_ramp_checker;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       test_en = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_is_ctrl = 1'b0;
    logic       rx_err = 1'b0;
    logic       pat_fail;

    int total = 0;
    int bad   = 0;
    bit done_flag = 0;

    // reference model state: -2 hunt, -1 idles seen, 1..255 next ramp value, 256 ramp complete
    int m_pos  = -2;
    bit m_fail = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    bist_ramp_checker u0 (
        .clk       (clk),
        .rst       (rst),
        .test_en   (test_en),
        .rx_byte   (rx_byte),
        .rx_is_ctrl(rx_is_ctrl),
        .rx_err    (rx_err),
        .pat_fail  (pat_fail)
    );

    task automatic model(input logic [7:0] b, input logic c, input logic e);
        bit idle;
        bit dat;
        bit mis;
        idle = c && (b == 8'hBC);
        dat  = !c;
        mis  = 0;
        if (rst || !test_en) begin
            m_fail = 1; m_pos = -2;
        end else if (e) begin
            mis = 1;
        end else if (m_pos == -2) begin
            if (idle) m_pos = -1;
        end else if (m_pos == -1) begin
            if (idle) m_pos = -1;
            else if (dat && b == 8'h00) m_pos = 1;
            else mis = 1;
        end else if (m_pos == 256) begin
            if (idle) m_pos = -1;
            else mis = 1;
        end else begin
            if (dat && int'(b) == m_pos) begin
                m_pos++;
                if (m_pos == 256) m_fail = 0;
            end else mis = 1;
        end
        if (mis) begin
            m_fail = 1; m_pos = -2;
        end
    endtask

    task automatic check(input string tag);
        total++;
        if (pat_fail !== m_fail) begin
            bad++;
            $display("FAIL %s: pat_fail actual=%0b expected=%0b at %0t", tag, pat_fail, m_fail, $time);
        end
    endtask

    task automatic step(input logic [7:0] b, input logic c, input logic e, input string tag);
        rx_byte = b; rx_is_ctrl = c; rx_err = e;
        @(posedge clk);
        model(b, c, e);
        @(negedge clk);
        check(tag);
    endtask

    task automatic idles(input int n, input string tag);
        for (int i = 0; i < n; i++) step(8'hBC, 1'b1, 1'b0, tag);
    endtask

    task automatic ramp(input string tag, input int bad_at, input logic [7:0] bad_b,
                        input logic bad_c, input int err_at);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            logic       c;
            b = 8'(i);
            c = 1'b0;
            if (i == bad_at) begin b = bad_b; c = bad_c; end
            step(b, c, (i == err_at), tag);
        end
    endtask

    task automatic expect_now(input logic v, input string tag);
        total++;
        if (pat_fail !== v) begin
            bad++;
            $display("FAIL %s: pat_fail actual=%0b expected=%0b at %0t", tag, pat_fail, v, $time);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset
        idles(3, "R1");
        rst = 0;
        step(8'h00, 1'b0, 1'b0, "R1");
        expect_now(1'b1, "R1");

        // R2 disabled: a full clean frame changes nothing
        idles(2, "R2");
        ramp("R2", -1, 8'h00, 1'b0, -1);
        expect_now(1'b1, "R2");

        // R3 / R4 / R5 enable, then a first clean frame
        test_en = 1;
        idles(3, "R3");
        expect_now(1'b1, "R3");
        ramp("R5", -1, 8'h00, 1'b0, -1);
        expect_now(1'b0, "R5");

        // R12 repeated frames keep passing
        idles(1, "R12");
        ramp("R12", -1, 8'h00, 1'b0, -1);
        idles(5, "R12");
        ramp("R12", -1, 8'h00, 1'b0, -1);
        expect_now(1'b0, "R12");

        // R7 wrong data value in mid ramp
        idles(2, "R7");
        ramp("R7", 100, 8'h37, 1'b0, -1);
        expect_now(1'b1, "R7");

        // R10 hunt: a ramp without idle does not count
        ramp("R10", -1, 8'h00, 1'b0, -1);
        expect_now(1'b1, "R10");
        idles(1, "R10");
        ramp("R10", -1, 8'h00, 1'b0, -1);
        expect_now(1'b0, "R10");

        // R8 foreign control character, then idle inside ramp
        idles(1, "R8");
        ramp("R8", 50, 8'hFC, 1'b1, -1);
        expect_now(1'b1, "R8");
        idles(2, "R8");
        ramp("R8", 30, 8'hBC, 1'b1, -1);
        idles(1, "R8");
        ramp("R8", -1, 8'h00, 1'b0, -1);
        expect_now(1'b0, "R8");
        step(8'h7C, 1'b1, 1'b0, "R8");
        expect_now(1'b1, "R8");

        // R9 data directly after a completed ramp
        idles(1, "R9");
        ramp("R9", -1, 8'h00, 1'b0, -1);
        step(8'h00, 1'b0, 1'b0, "R9");
        expect_now(1'b1, "R9");

        // R11 first data byte not zero
        idles(1, "R11");
        ramp("R11", -1, 8'h00, 1'b0, -1);
        idles(2, "R11");
        step(8'h05, 1'b0, 1'b0, "R11");
        expect_now(1'b1, "R11");

        // R6 decoder error on a matching byte, mid ramp and on the last byte
        idles(1, "R6");
        ramp("R6", -1, 8'h00, 1'b0, -1);
        idles(1, "R6");
        ramp("R6", -1, 8'h00, 1'b0, 200);
        expect_now(1'b1, "R6");
        idles(1, "R6");
        ramp("R6", -1, 8'h00, 1'b0, 255);
        expect_now(1'b1, "R6");
        idles(1, "R6");
        ramp("R6", -1, 8'h00, 1'b0, -1);
        step(8'hBC, 1'b1, 1'b1, "R6");
        expect_now(1'b1, "R6");

        // R2 / R3 drop enable after a pass, then raise it again
        idles(1, "R3");
        ramp("R3", -1, 8'h00, 1'b0, -1);
        expect_now(1'b0, "R3");
        test_en = 0;
        idles(1, "R2");
        expect_now(1'b1, "R2");
        test_en = 1;
        idles(1, "R3");
        expect_now(1'b1, "R3");
        ramp("R4", -1, 8'h00, 1'b0, -1);
        expect_now(1'b0, "R4");

        // R2 disable on the cycle of the final ramp byte
        idles(1, "R2");
        for (int i = 0; i < 255; i++) step(8'(i), 1'b0, 1'b0, "R2");
        test_en = 0;
        step(8'hFF, 1'b0, 1'b0, "R2");
        expect_now(1'b1, "R2");
        test_en = 1;

        // R1 reset in the middle of a passing stream
        idles(1, "R1");
        ramp("R1", -1, 8'h00, 1'b0, -1);
        rst = 1;
        step(8'hBC, 1'b1, 1'b0, "R1");
        expect_now(1'b1, "R1");
        rst = 0;
        idles(1, "R1");

        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule